// File: doc/BRIEF.md
# Tick-Paced 8-bit Pulse-Width Generator

The block turns an 8-bit level into a pulse train on one output pin. Time is cut into timeslots by a programmable clock divider: every `tickDivisor` system clocks one tick pulse is produced. An 8-bit slot counter advances once per tick, so one output period always spans 256 ticks. A pending bit is armed when the slot counter matches the held level. The counter's roll-over from its top value back to zero disarms it. The pin copies that pending bit at the start of each tick, before any compare or count, so every edge on the pin lands on a tick boundary and trails its cause by one tick.

The level input is captured only at the roll-over tick, so a period never sees a mix of two levels. A one-clock strobe marks the first clock of each new period. Software or a neighbouring block sets the divisor for the wanted slot rate. For example, a 50 Hz period needs ticks at 12.8 kHz, about 78.1 us apart. Writing a divisor of zero freezes the generator where it stands.

Top module: `pwm_tick_gen`

## Requirements
- R1: One output period is exactly 256 ticks. The slot counter steps by one per tick and rolls over from 255 to 0, so two consecutive period strobes are 256 x `tickDivisor` clocks apart.
- R2: With `tickDivisor` = N > 0, a tick occurs once every N clocks. With `tickDivisor` = 0, no tick occurs: `pwmOut` holds its value and `periodStart` stays low.
- R3: Take a level D that is held over two periods in a row. In the second of those periods, `pwmOut` is high for (255 - D) ticks. So D = 0 gives 255 high ticks, and D = 255 gives a pin that stays low for the whole period.
- R4: The pin is loaded from the pending bit at each tick, before the compare, so it trails the match by one tick. For D <= 253, the rising edge comes (D + 2) x N clocks after the period strobe.
- R5: `dutyIn` is captured only on the roll-over tick. A change during a period has no effect on the pin until the next roll-over.
- R6: `periodStart` is high for exactly one clock. That clock directly follows the clock edge on which the slot counter rolls to 0, and the strobe appears once per period.
- R7: The active-low asynchronous `rstN` clears the held level, the slot counter, the pending bit, the pin and the strobe. The first period after reset therefore acts as level 0, whatever `dutyIn` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickDivisor | input | 16 | System clocks per tick; 0 stops the generator |
| dutyIn | input | 8 | Level captured at each period roll-over |
| pwmOut | output | 1 | Registered pulse-width output |
| periodStart | output | 1 | One-clock strobe in the first clock of each period |

## Verification
The bench builds the block with its default widths: an 8-bit slot counter and a 16-bit divisor. It drives divisors of 1, 2 and 3, so a full 256-tick period takes at most 768 clocks. This keeps the level extremes 0, 254 and 255 in reach, along with the real roll-over from 255 to 0. Running the same levels at more than one divisor shows that high time and edge position scale with the tick length rather than with the clock. Stopping with divisor 0, the post-reset period and level changes made in the middle of a period are each driven as directed cases.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic tick;   // one-clock timeslot pulse
    logic wrap;   // tick on which the slot counter rolls to zero
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_tick_ctrl.sv
module pwm_tick_ctrl
  import pwm_tick_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] tickDivisor,
  output pwmStrobe_t       strobe,
  output logic [CNT_W-1:0] slotCount
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] divCnt;
  logic             tickNow;
  logic             divRun;

  assign divRun  = (tickDivisor != '0);
  // ">=" keeps the divider safe when the divisor shrinks mid-count.
  assign tickNow = divRun && (divCnt >= (tickDivisor - DIV_ONE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      slotCount <= '0;
    end else begin
      if (!divRun || tickNow) divCnt <= '0;
      else                    divCnt <= divCnt + DIV_ONE;
      if (tickNow) slotCount <= slotCount + 1'b1;
    end
  end

  always_comb begin
    strobe.tick = tickNow;
    strobe.wrap = tickNow && (slotCount == CNT_TOP);
  end

endmodule

// File: rtl/pwm_tick_dp.sv
module pwm_tick_dp
  import pwm_tick_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] slotCount,
  input  logic [CNT_W-1:0] dutyIn,
  output logic [CNT_W-1:0] dutyHeld,
  output logic             pwmOut,
  output logic             periodStart
);

  logic pendBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyHeld    <= '0;
      pendBit     <= 1'b0;
      pwmOut      <= 1'b0;
      periodStart <= 1'b0;
    end else begin
      periodStart <= strobe.wrap;
      if (strobe.tick) begin
        pwmOut <= pendBit;                        // pin first takes the old pending bit
        if (strobe.wrap)                   pendBit <= 1'b0;  // roll-over wins over a match
        else if (slotCount == dutyHeld)    pendBit <= 1'b1;
      end
      if (strobe.wrap) dutyHeld <= dutyIn;        // level changes only between periods
    end
  end

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] tickDivisor,
  input  logic [CNT_W-1:0] dutyIn,
  output logic             pwmOut,
  output logic             periodStart
);

  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] slotCount;
  logic [CNT_W-1:0] dutyHeld;

  pwm_tick_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickDivisor(tickDivisor),
    .strobe     (strobe),
    .slotCount  (slotCount)
  );

  pwm_tick_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slotCount  (slotCount),
    .dutyIn     (dutyIn),
    .dutyHeld   (dutyHeld),
    .pwmOut     (pwmOut),
    .periodStart(periodStart)
  );

endmodule

// File: rtl/pwm_tick_chk.sv
module pwm_tick_chk
  import pwm_tick_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] tickDivisor,
  input pwmStrobe_t       strobe,
  input logic [CNT_W-1:0] slotCount,
  input logic [CNT_W-1:0] dutyHeld,
  input logic             pwmOut,
  input logic             periodStart
);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> (slotCount == CNT_W'($past(slotCount) + 1'b1)));

  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickDivisor == '0) |=> ($stable(pwmOut) && !periodStart));

  assert_pin_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(pwmOut));

  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrap |=> $stable(dutyHeld));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (periodStart && slotCount == '0));

endmodule

bind pwm_tick_gen pwm_tick_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickDivisor(tickDivisor),
  .strobe     (strobe),
  .slotCount  (slotCount),
  .dutyHeld   (dutyHeld),
  .pwmOut     (pwmOut),
  .periodStart(periodStart)
);

// File: tb/pwm_tick_gen_bench.sv
`timescale 1ns/1ps
module pwm_tick_gen_bench;

  localparam int NV = 8;
  localparam int WATCH = 150000;
  // divisor, level, level written mid-window (must be ignored)
  localparam logic [15:0] V_DIV [NV] = '{16'd1, 16'd1, 16'd2, 16'd3, 16'd1, 16'd2, 16'd3, 16'd2};
  localparam logic [7:0]  V_DUTY[NV] = '{8'd0, 8'd255, 8'd128, 8'd64, 8'd254, 8'd1, 8'd253, 8'd100};
  localparam logic [7:0]  V_GLT [NV] = '{8'd37, 8'd5, 8'd254, 8'd0, 8'd255, 8'd200, 8'd7, 8'd3};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tickDivisor = '0;
  logic [7:0]  dutyIn = '0;
  logic        pwmOut;
  logic        periodStart;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pwm_tick_gen u_pwm_tick_gen (
    .clk(clk), .rstN(rstN), .tickDivisor(tickDivisor), .dutyIn(dutyIn),
    .pwmOut(pwmOut), .periodStart(periodStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!periodStart && !done);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCH && !done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int hi, len, rise, d, dv, changes, strobes;
    bit prev;
    // R7: reset state
    tickDivisor = 16'd1;
    dutyIn = 8'd200;
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R7 pin in reset", pwmOut, 0);
    check(periodStart == 1'b0, "R7 strobe in reset", periodStart, 0);
    rstN = 1'b1;
    // R7/R5/R1: first period acts as level 0 regardless of dutyIn
    hi = 0; len = 0;
    do begin
      @(negedge clk);
      if (!periodStart) begin hi += pwmOut; len++; end
    end while (!periodStart && !done);
    check(hi == 254, "R7 first period high count", hi, 254);
    check(len == 255, "R1 clocks before first strobe", len, 255);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      dv = int'(V_DIV[v]); d = int'(V_DUTY[v]);
      tickDivisor = V_DIV[v];
      dutyIn = V_DUTY[v];
      waitStrobe();       // level latched here
      waitStrobe();       // second period with the same level, then measure
      hi = 0; len = 0; rise = -1; prev = 1'b0;
      do begin
        hi += pwmOut;
        if (len > 0 && pwmOut && !prev && rise < 0) rise = len;
        prev = pwmOut;
        if (len == 5) dutyIn = V_GLT[v];   // R5: ignored until next roll-over
        @(negedge clk);
        len++;
      end while (!periodStart && !done);
      check(len == 256 * dv, "R1 period length", len, 256 * dv);
      check(hi == (255 - d) * dv, "R3/R5 high clocks", hi, (255 - d) * dv);
      if (d <= 253) check(rise == (d + 2) * dv, "R4 rise offset", rise, (d + 2) * dv);
      // R6: strobe is a single clock
      @(negedge clk);
      check(periodStart == 1'b0, "R6 strobe width", periodStart, 0);
    end

    // R2: divisor zero freezes the pin and the strobe
    tickDivisor = 16'd1; dutyIn = 8'd0;
    waitStrobe(); waitStrobe();
    repeat (100) @(negedge clk);
    tickDivisor = 16'd0;
    prev = pwmOut; changes = 0; strobes = 0;
    repeat (1000) begin
      @(negedge clk);
      if (pwmOut != prev) changes++;
      strobes += periodStart;
      prev = pwmOut;
    end
    check(changes == 0, "R2 pin frozen at divisor 0", changes, 0);
    check(strobes == 0, "R2 no strobe at divisor 0", strobes, 0);
    // R2: restart resumes normal periods
    tickDivisor = 16'd1;
    waitStrobe();
    len = 0;
    do begin @(negedge clk); len++; end while (!periodStart && !done);
    check(len == 256, "R2 restart period length", len, 256);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule